// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a ring of transmit descriptors kept in a small descriptor memory. Each descriptor is two 32-bit words. Word 0 holds a 16-bit status field in bits 31:16 and the byte length in bits 15:0. Word 1 holds the byte address of the buffer. When software marks a descriptor ready, the engine reads the buffer address, fetches the bytes from a buffer memory and presents them one at a time on a byte-wide transmit stream. The stream carries start-of-frame and end-of-frame markers and a flag that asks the downstream serializer to append a CRC. The engine then writes word 0 back with the ready flag cleared, which hands the descriptor back to software.

Status bits, numbered within the status field: ready is bit 15 (word bit 31), wrap is bit 13 (word bit 29), last is bit 11 (word bit 27), append-CRC is bit 10 (word bit 26), and the reject flag that the engine sets is bit 1 (word bit 17). A frame can span several descriptors. Only the descriptor that has the last flag ends the frame.

The engine walks forward until it meets a descriptor that is not ready. It then goes idle and waits for a one-cycle continue pulse before it fetches the same descriptor again. A stop request lets the frame in progress complete. The engine then parks, gives a one-cycle completion pulse, and stays parked while the request is held.

States:
- IDLE waits for a continue pulse or a stop request.
- STS_REQ reads word 0.
- STS_CAP checks the ready flag and the length.
- PTR_REQ reads word 1.
- PTR_CAP stores the buffer address.
- BYTE_REQ reads one buffer byte.
- BYTE_OUT presents that byte.
- RETIRE writes the status back and advances the index.
- HALT is the parked state.

Transitions:
- IDLE to STS_REQ on continue.
- IDLE to HALT on stop.
- STS_CAP to IDLE when the descriptor is not ready.
- STS_CAP to RETIRE when the length is bad.
- STS_CAP to PTR_REQ otherwise.
- PTR_REQ to PTR_CAP to BYTE_REQ.
- BYTE_REQ to BYTE_OUT.
- BYTE_OUT back to BYTE_REQ until the final byte, then to RETIRE.
- RETIRE to HALT when stop is requested and no frame is open.
- RETIRE to STS_REQ otherwise.
- HALT to IDLE once stop is released.

Both memory ports return read data in the cycle after the request.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset every output is low and the first descriptor fetched after a continue pulse is descriptor 0, at word address 0.
- R2: A continue pulse in idle reads word 0 of the current descriptor, at word address 2×index. If its ready flag (word bit 31) is clear, the engine sends nothing, writes nothing and stays idle on that index until the next continue pulse.
- R3: For a ready descriptor of length L, exactly L bytes are presented with tx_valid, taken from buffer addresses base..base+L-1 in ascending order.
- R4: tx_sof marks the first byte of a frame. A frame starts at the first byte after reset or after a descriptor with the last flag (word bit 27).
- R5: tx_eof marks the final byte of a descriptor whose last flag is set, and never any other byte.
- R6: tx_crc is high together with tx_eof when that descriptor's append-CRC flag (word bit 26) is set, and low at all other times.
- R7: Retiring a descriptor writes word 0 back with bit 31 cleared. All other bits are unchanged unless R8 applies.
- R8: A length of 0 or greater than 1500 is rejected. No byte is sent, and the write-back clears bit 31 and sets the reject flag, word bit 17.
- R9: After a descriptor with the wrap flag (word bit 29), the index returns to 0. Otherwise it advances by one.
- R10: After a retire the engine fetches the next descriptor without a further continue pulse.
- R11: A stop request lets the current frame finish and then parks the engine. stop_done pulses for exactly one cycle. While the request is held, nothing is fetched or sent. After release the engine waits for a continue pulse. A stop request while idle parks the engine at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Continue pulse that wakes the idle engine |
| stop_req | input | 1 | Graceful stop request, level |
| stop_done | output | 1 | One-cycle pulse when the engine has parked |
| desc_rd | output | 1 | Descriptor memory read strobe |
| desc_we | output | 1 | Descriptor memory write strobe |
| desc_addr | output | IDX_W+1 (4) | Descriptor word address: index and word select |
| desc_wdata | output | 32 | Write-back word 0 |
| desc_rdata | input | 32 | Read data, valid the cycle after desc_rd |
| buf_rd | output | 1 | Buffer memory read strobe |
| buf_addr | output | ADDR_W (32) | Buffer byte address |
| buf_rdata | input | 8 | Buffer byte, valid the cycle after buf_rd |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Final byte of a frame |
| tx_crc | output | 1 | Append-CRC request, with tx_eof |

## Verification
The main function is driven four ways: directed rings of single-byte and short frames, descriptors with bad lengths at both ends of the legal range (0, 1500 and 1501), frames split over several descriptors, and seeded random rings of up to four descriptors with random flags and buffer bases. The directed rings separate marker placement (start, end and CRC flag) from byte ordering. The length cases show that the reject rule sits exactly at the limit. Split frames show that only the last-flagged descriptor closes a frame. The random rings compare the byte stream and every descriptor word after each run against a bench model, and they also check, through the address of the next fetch, where the index ended after each wrap.

// File: rtl/tde_pkg.sv
package tde_pkg;

    localparam int DESC_W   = 32;
    localparam int LEN_W    = 16;

    // status field bit positions (status occupies word bits 31:16)
    localparam int ST_READY  = 15;
    localparam int ST_WRAP   = 13;
    localparam int ST_LAST   = 11;
    localparam int ST_CRC    = 10;
    localparam int ST_REJECT = 1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STS_REQ,
        S_STS_CAP,
        S_PTR_REQ,
        S_PTR_CAP,
        S_BYTE_REQ,
        S_BYTE_OUT,
        S_RETIRE,
        S_HALT
    } tde_state_e;

    function automatic logic len_bad(input logic [LEN_W-1:0] len, input int max_len);
        return (len == '0) || (int'(len) > max_len);
    endfunction

endpackage

// File: rtl/tde_ring_ptr.sv
module tde_ring_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            if (wrap || (idx == LAST_IDX))
                idx <= '0;
            else
                idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/tde_byte_cnt.sv
module tde_byte_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/tde_ctrl.sv
module tde_ctrl
    import tde_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = 32,
    parameter int MAX_LEN = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              stop_req,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LEN_W-1:0]  count,
    input  logic [DESC_W-1:0] desc_rdata,
    input  logic [7:0]        buf_rdata,
    output logic              ptr_adv,
    output logic              ptr_wrap,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              desc_rd,
    output logic              desc_we,
    output logic [IDX_W:0]    desc_addr,
    output logic [DESC_W-1:0] desc_wdata,
    output logic              buf_rd,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              tx_crc,
    output logic              stop_done
);
    tde_state_e         state_q, state_d;
    logic [15:0]        sts_q;
    logic [LEN_W-1:0]   len_q;
    logic [ADDR_W-1:0]  base_q;
    logic               reject_q;
    logic               in_frame_q;
    logic               in_frame_d;
    logic               stop_done_q;
    logic               last_byte;
    logic               cap_ready;
    logic               cap_bad;

    assign cap_ready = desc_rdata[16 + ST_READY];
    assign cap_bad   = len_bad(desc_rdata[LEN_W-1:0], MAX_LEN);
    assign last_byte = (count == (len_q - 1'b1));

    // frame state after the descriptor now retiring
    always_comb begin
        in_frame_d = in_frame_q;
        if (state_q == S_RETIRE && !reject_q)
            in_frame_d = !sts_q[ST_LAST];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (stop_req)
                    state_d = S_HALT;
                else if (kick)
                    state_d = S_STS_REQ;
            end
            S_STS_REQ:  state_d = S_STS_CAP;
            S_STS_CAP: begin
                if (!cap_ready)
                    state_d = S_IDLE;
                else if (cap_bad)
                    state_d = S_RETIRE;
                else
                    state_d = S_PTR_REQ;
            end
            S_PTR_REQ:  state_d = S_PTR_CAP;
            S_PTR_CAP:  state_d = S_BYTE_REQ;
            S_BYTE_REQ: state_d = S_BYTE_OUT;
            S_BYTE_OUT: state_d = last_byte ? S_RETIRE : S_BYTE_REQ;
            S_RETIRE: begin
                if (stop_req && !in_frame_d)
                    state_d = S_HALT;
                else
                    state_d = S_STS_REQ;
            end
            S_HALT: begin
                if (!stop_req)
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured descriptor fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            sts_q       <= '0;
            len_q       <= '0;
            base_q      <= '0;
            reject_q    <= 1'b0;
            in_frame_q  <= 1'b0;
            stop_done_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            in_frame_q  <= in_frame_d;
            stop_done_q <= (state_d == S_HALT) && (state_q != S_HALT);
            if (state_q == S_STS_CAP) begin
                sts_q    <= desc_rdata[31:16];
                len_q    <= desc_rdata[LEN_W-1:0];
                reject_q <= cap_bad;
            end
            if (state_q == S_PTR_CAP)
                base_q <= desc_rdata[ADDR_W-1:0];
        end
    end

    // outputs decoded from state
    always_comb begin
        desc_rd    = 1'b0;
        desc_we    = 1'b0;
        desc_addr  = {idx, 1'b0};
        desc_wdata = '0;
        buf_rd     = 1'b0;
        tx_valid   = 1'b0;
        tx_sof     = 1'b0;
        tx_eof     = 1'b0;
        tx_crc     = 1'b0;
        ptr_adv    = 1'b0;
        ptr_wrap   = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        unique case (state_q)
            S_IDLE, S_HALT, S_STS_CAP, S_PTR_CAP: ;
            S_STS_REQ: begin
                desc_rd = 1'b1;
                cnt_clr = 1'b1;
            end
            S_PTR_REQ: begin
                desc_rd   = 1'b1;
                desc_addr = {idx, 1'b1};
            end
            S_BYTE_REQ: buf_rd = 1'b1;
            S_BYTE_OUT: begin
                tx_valid = 1'b1;
                tx_sof   = (count == '0) && !in_frame_q;
                tx_eof   = last_byte && sts_q[ST_LAST];
                tx_crc   = last_byte && sts_q[ST_LAST] && sts_q[ST_CRC];
                cnt_inc  = 1'b1;
            end
            S_RETIRE: begin
                desc_we  = 1'b1;
                ptr_adv  = 1'b1;
                ptr_wrap = sts_q[ST_WRAP];
                desc_wdata[31:16]   = sts_q;
                desc_wdata[16 + ST_READY] = 1'b0;
                if (reject_q)
                    desc_wdata[16 + ST_REJECT] = 1'b1;
                desc_wdata[LEN_W-1:0] = len_q;
            end
            default: ;
        endcase
    end

    assign buf_addr  = base_q + ADDR_W'(count);
    assign tx_data   = tx_valid ? buf_rdata : 8'h00;
    assign stop_done = stop_done_q;

endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 32,
    parameter int MAX_LEN = 1500,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              stop_req,
    output logic              stop_done,
    output logic              desc_rd,
    output logic              desc_we,
    output logic [IDX_W:0]    desc_addr,
    output logic [31:0]       desc_wdata,
    input  logic [31:0]       desc_rdata,
    output logic              buf_rd,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              tx_crc
);
    import tde_pkg::*;

    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] count;
    logic             ptr_adv, ptr_wrap, cnt_clr, cnt_inc;

    tde_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ptr_adv),
        .wrap    (ptr_wrap),
        .idx     (idx)
    );

    tde_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    tde_ctrl #(
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .MAX_LEN (MAX_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (kick),
        .stop_req   (stop_req),
        .idx        (idx),
        .count      (count),
        .desc_rdata (desc_rdata),
        .buf_rdata  (buf_rdata),
        .ptr_adv    (ptr_adv),
        .ptr_wrap   (ptr_wrap),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .desc_rd    (desc_rd),
        .desc_we    (desc_we),
        .desc_addr  (desc_addr),
        .desc_wdata (desc_wdata),
        .buf_rd     (buf_rd),
        .buf_addr   (buf_addr),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_sof     (tx_sof),
        .tx_eof     (tx_eof),
        .tx_crc     (tx_crc),
        .stop_done  (stop_done)
    );
endmodule

// File: rtl/tde_checker.sv
module tde_checker #(
    parameter int AW      = 4,
    parameter int MAX_LEN = 1500
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_req,
    input logic          stop_done,
    input logic          desc_rd,
    input logic          desc_we,
    input logic [AW-1:0] desc_addr,
    input logic [31:0]   desc_wdata,
    input logic          buf_rd,
    input logic          tx_valid,
    input logic          tx_sof,
    input logic          tx_eof,
    input logic          tx_crc
);
    // R4, R5: frame markers only ride on a valid byte
    a_r4_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);

    // R6: the CRC request never appears without end of frame
    a_r6_crc_only_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
        tx_crc |-> tx_eof);

    // R3: every buffer read yields a byte on the next cycle
    a_r3_byte_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> tx_valid);

    // R3: one memory or stream action per cycle
    a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_rd, desc_we, buf_rd, tx_valid}));

    // R7: write-back targets word 0 and hands ownership back
    a_r7_retire_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (!desc_wdata[31] && !desc_addr[0]));

    // R8: the reject flag only appears for an illegal length
    a_r8_reject_only_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && desc_wdata[17]) |->
        ((desc_wdata[15:0] == 16'd0) || (int'(desc_wdata[15:0]) > MAX_LEN)));

    // R11: completion is a single-cycle pulse
    a_r11_done_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> !stop_done);

    // R11: parked engine stays quiet while the request is held
    a_r11_quiet_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && stop_req) |=> (!desc_rd && !tx_valid && !buf_rd));
endmodule

bind tx_desc_engine tde_checker #(.AW(IDX_W + 1), .MAX_LEN(MAX_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .stop_done  (stop_done),
    .desc_rd    (desc_rd),
    .desc_we    (desc_we),
    .desc_addr  (desc_addr),
    .desc_wdata (desc_wdata),
    .buf_rd     (buf_rd),
    .tx_valid   (tx_valid),
    .tx_sof     (tx_sof),
    .tx_eof     (tx_eof),
    .tx_crc     (tx_crc)
);

// File: tb/tx_desc_engine_bench.sv
module tx_desc_engine_bench;
    localparam int DEPTH = 8;
    localparam int MAXL  = 1500;

    logic        clk = 1'b0;
    logic        rst_n, kick, stop_req;
    logic        stop_done, desc_rd, desc_we, buf_rd;
    logic [3:0]  desc_addr;
    logic [31:0] desc_wdata, desc_rdata;
    logic [31:0] buf_addr;
    logic [7:0]  buf_rdata, tx_data;
    logic        tx_valid, tx_sof, tx_eof, tx_crc;

    always #10 clk = ~clk;

    tx_desc_engine #(.DEPTH(DEPTH)) u_tx_desc_engine (
        .clk(clk), .rst_n(rst_n), .kick(kick), .stop_req(stop_req),
        .stop_done(stop_done), .desc_rd(desc_rd), .desc_we(desc_we),
        .desc_addr(desc_addr), .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
        .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_crc(tx_crc)
    );

    logic [31:0] dmem [2*DEPTH];
    logic [31:0] mdesc [2*DEPTH];
    logic [7:0]  bmem [4096];

    // memory models, one-cycle read latency
    always @(posedge clk) begin
        if (desc_rd) desc_rdata <= dmem[desc_addr];
        if (desc_we) dmem[desc_addr] <= desc_wdata;
        if (buf_rd)  buf_rdata <= bmem[buf_addr[11:0]];
    end

    logic [10:0] got_q [$];
    logic [10:0] exp_q [$];
    int          rd_addr_q [$];
    int          done_cnt = 0;
    int          nchk = 0;
    int          nfail = 0;
    bit          finished = 0;
    int          m_idx = 0;
    bit          m_inframe = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) got_q.push_back({tx_crc, tx_eof, tx_sof, tx_data});
            if (desc_rd)  rd_addr_q.push_back(int'(desc_addr));
            if (stop_done) done_cnt++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_desc(bit rdy, bit wrp, bit lst, bit crc, int len);
        logic [31:0] w = '0;
        w[31] = rdy; w[29] = wrp; w[27] = lst; w[26] = crc;
        w[15:0] = 16'(len);
        return w;
    endfunction

    task automatic set_desc(int i, bit rdy, bit lst, bit crc, int len, int base);
        dmem[2*i]   = mk_desc(rdy, (i == DEPTH-1), lst, crc, len);
        dmem[2*i+1] = base;
    endtask

    // reference walk of the ring, up to maxd descriptors
    task automatic run_model(int maxd);
        for (int n = 0; n < maxd; n++) begin
            logic [31:0] w = mdesc[2*m_idx];
            int len = int'(w[15:0]);
            int base = int'(mdesc[2*m_idx+1]);
            if (!w[31]) break;
            if (len == 0 || len > MAXL) begin
                w[17] = 1'b1;
            end else begin
                for (int b = 0; b < len; b++) begin
                    bit s = (b == 0) && !m_inframe;
                    bit e = (b == len-1) && w[27];
                    bit c = e && w[26];
                    exp_q.push_back({c, e, s, bmem[(base + b) & 4095]});
                end
                m_inframe = !w[27];
            end
            w[31] = 1'b0;
            mdesc[2*m_idx] = w;
            m_idx = (w[29] || m_idx == DEPTH-1) ? 0 : m_idx + 1;
        end
    endtask

    task automatic kick_pulse();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            if (desc_rd || desc_we || buf_rd || tx_valid) q = 0; else q++;
        end
    endtask

    task automatic compare(string req);
        chk(req, "byte count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(req, $sformatf("beat %0d {crc,eof,sof,data}", i), 32'(got_q[i]), 32'(exp_q[i]));
        for (int i = 0; i < 2*DEPTH; i++)
            chk("R7", $sformatf("descriptor word %0d", i), dmem[i], mdesc[i]);
    endtask

    task automatic run_and_compare(string req);
        int first = 2*m_idx;
        for (int i = 0; i < 2*DEPTH; i++) mdesc[i] = dmem[i];
        got_q.delete(); exp_q.delete(); rd_addr_q.delete();
        kick_pulse();
        wait_quiet();
        run_model(DEPTH + 1);
        chk("R9", "first fetch address", rd_addr_q.size() > 0 ? rd_addr_q[0] : -1, first);
        compare(req);
    endtask

    initial begin
        int unused_seed;
        int i;
        int d;
        unused_seed = $urandom(32'h1D5C);
        rst_n = 1'b0; kick = 1'b0; stop_req = 1'b0;
        for (int k = 0; k < 4096; k++) bmem[k] = 8'($urandom());
        for (int k = 0; k < 2*DEPTH; k++) dmem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk("R1", "outputs after reset",
            {26'b0, stop_done, desc_rd, desc_we, buf_rd, tx_valid, tx_sof | tx_eof | tx_crc}, 32'd0);

        // R2: nothing ready; R1: first fetch is descriptor 0
        run_and_compare("R2");
        chk("R2", "single fetch on empty ring", rd_addr_q.size(), 1);
        chk("R1", "first fetch address", rd_addr_q[0], 0);

        // R3, R4, R5, R6, R10: two short frames back to back
        set_desc(0, 1, 1, 1, 1, 100);
        set_desc(1, 1, 1, 0, 3, 200);
        run_and_compare("R3");

        // R8: zero, over-limit and exactly-limit lengths
        set_desc(2, 1, 1, 0, 0, 300);
        set_desc(3, 1, 1, 1, MAXL + 1, 400);
        set_desc(4, 1, 1, 1, MAXL, 500);
        run_and_compare("R8");

        // R9: early wrap flag at index 5
        dmem[10] = mk_desc(1, 1, 1, 0, 4);
        dmem[11] = 32'd2100;
        set_desc(0, 1, 1, 1, 2, 50);
        dmem[2] = '0;
        run_and_compare("R9");
        chk("R9", "index after wrap", m_idx, 1);
        dmem[10] = '0;

        // R4, R5: frame split over descriptors (last clear, then set)
        set_desc(1, 1, 0, 1, 5, 700);
        set_desc(2, 1, 0, 0, 2, 800);
        set_desc(3, 1, 1, 1, 3, 900);
        dmem[8] = '0;
        run_and_compare("R4");

        // R2: idle on not-ready, then it becomes ready and a kick picks it up
        set_desc(4, 0, 1, 0, 6, 1000);
        run_and_compare("R2");
        set_desc(4, 1, 1, 0, 6, 1000);
        dmem[10] = '0;
        run_and_compare("R10");

        // seeded random rings
        for (int r = 0; r < 24; r++) begin
            int k = 1 + $urandom_range(0, 3);
            i = m_idx;
            for (int j = 0; j < k; j++) begin
                int len = (r % 7 == 3) ? (($urandom_range(0, 1) == 1) ? 0 : MAXL + 1 + $urandom_range(0, 50))
                                       : 1 + $urandom_range(0, 47);
                set_desc(i, 1, $urandom_range(0, 3) != 0, $urandom_range(0, 1), len,
                         $urandom_range(0, 2500));
                i = (i == DEPTH-1) ? 0 : i + 1;
            end
            dmem[2*i][31] = 1'b0;
            run_and_compare("R3");
        end

        // make sure the model has no open frame before the stop test
        i = m_idx;
        set_desc(i, 1, 1, 0, 1, 10);
        d = (i == DEPTH-1) ? 0 : i + 1;
        dmem[2*d][31] = 1'b0;
        run_and_compare("R5");

        // R11: stop during a frame
        i = m_idx;
        for (int j = 0; j < 3; j++) begin
            set_desc(i, 1, 1, 1, 10, 1200 + 20*j);
            i = (i == DEPTH-1) ? 0 : i + 1;
        end
        dmem[2*i][31] = 1'b0;
        for (int k = 0; k < 2*DEPTH; k++) mdesc[k] = dmem[k];
        got_q.delete(); exp_q.delete(); rd_addr_q.delete();
        done_cnt = 0;
        kick_pulse();
        while (!tx_valid) @(negedge clk);
        stop_req = 1'b1;
        while (done_cnt == 0) @(negedge clk);
        repeat (12) @(negedge clk);
        run_model(1);
        compare("R11");
        chk("R11", "stop_done pulses", done_cnt, 1);
        d = rd_addr_q.size();
        stop_req = 1'b0;
        repeat (12) @(negedge clk);
        chk("R11", "no fetch after release without kick", rd_addr_q.size(), d);
        run_and_compare("R11");

        // R11: stop while idle parks at once
        done_cnt = 0;
        @(negedge clk) stop_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11", "idle stop pulse", done_cnt, 1);
        @(negedge clk) stop_req = 1'b0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule